// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block sits beside a processor core and decides what the core does when a debug event fires. Four mode-enable bits (internal debug, external debug, debug-interrupt, debug-wait) and a "wait allowed" flag from the debug port select among three reactions. The block can raise a debug-interrupt request. It can freeze the core in a debug-wait state. It can emit a trace trigger pulse for an external trace capture device.

While the core is frozen in debug-wait, the debug port can stop, run or single-step it. An external interrupt still gets serviced: the core is released to run the handler, and on return-from-interrupt it goes back to frozen rather than to normal execution. Freezing halts only instruction execution, and the bus side of the core is not touched by this block. A 2-bit status code reports the controller state. The reset is synchronous and active-low.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: On a debug event with external debug enable = 1 and debug-interrupt enable = 1, `dbg_irq_req` is high for exactly the one cycle after the event. Under any other enable combination it stays low.
- R2: From running, a debug event with internal debug enable = 0, external debug enable = 0, debug-wait enable = 1 and `port_wait_ok` = 1 makes `core_freeze` high and status 01 from the next cycle. With any one of these conditions missing, the state stays running.
- R3: While frozen, `ext_irq` moves to servicing on the next cycle: status 10, `core_freeze` low, `irq_grant` high. `irq_return` while servicing returns to frozen (status 01), not to running.
- R4: On a debug event with internal debug enable = 0, external debug enable = 0 and debug-wait enable = 0, `trace_trig` is high for exactly the one cycle after the event.
- R5: No trace trigger is produced while internal debug enable, external debug enable or debug-wait enable is 1.
- R6: While frozen, `cmd_step` moves to stepping (status 11, `core_freeze` low). The first `insn_done` strobe in stepping returns to frozen on the next cycle.
- R7: While frozen, `cmd_run` without `ext_irq` returns to running (status 00, `core_freeze` low) and discards any held step.
- R8: `cmd_stop` while stepping refreezes on the next cycle. While frozen, it has no effect.
- R9: If `ext_irq` and `cmd_step` arrive in the same cycle while frozen, the interrupt is serviced first. The step is held, and it starts on the first cycle back in frozen that has neither `ext_irq` nor `cmd_run`.
- R10: The status encoding is 00 running, 01 frozen, 10 servicing an interrupt from frozen, 11 stepping. `core_freeze` is high only in status 01, and `irq_grant` only in status 10.
- R11: While `rst_n` is low at a clock edge, the controller goes to running with `core_freeze`, `dbg_irq_req`, `irq_grant` and `trace_trig` low.
- R12: Debug-port commands while running have no effect. Debug events outside the running state do not change the state, although R1 and R4 pulses still follow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_dbg_en | input | 1 | Internal debug mode enable |
| ext_dbg_en | input | 1 | External debug mode enable |
| dbg_irq_en | input | 1 | Debug interrupt enable |
| dwait_en | input | 1 | Debug-wait mode enable |
| port_wait_ok | input | 1 | Debug port permits debug wait |
| dbg_event | input | 1 | Debug event pulse |
| ext_irq | input | 1 | External interrupt request |
| irq_return | input | 1 | Return from interrupt handler |
| cmd_stop | input | 1 | Debug port stop command |
| cmd_run | input | 1 | Debug port run command |
| cmd_step | input | 1 | Debug port single-step command |
| insn_done | input | 1 | Instruction-complete strobe from the core |
| core_freeze | output | 1 | Halts core instruction execution |
| dbg_irq_req | output | 1 | Debug interrupt request pulse |
| irq_grant | output | 1 | Core may run an interrupt handler from frozen |
| trace_trig | output | 1 | Trace trigger pulse |
| status | output | 2 | Controller status code |

## Verification
The bench targets the interrupt-and-step collision. A design that dropped the held step would stay frozen after the handler returns. A design that gave the step priority would show status 11 while the interrupt waits. The return path is probed as well: a controller that sent `irq_return` back to running would clear `core_freeze`. Trace suppression under debug-wait enable, and `port_wait_ok` gating of the freeze, are driven one enable at a time so that a missing term shows up as a stray pulse or a false freeze. A long pseudo-random stretch with occasional resets compares every output against the behavioural model on every cycle.

// File: rtl/dbgm_pkg.sv
// Package: shared state encoding of the debug mode controller.
// The state code doubles as the externally visible status code.
package dbgm_pkg;
    localparam int STATUS_W = 2;

    typedef enum logic [STATUS_W-1:0] {
        ST_RUN    = 2'b00,
        ST_FROZEN = 2'b01,
        ST_SERVE  = 2'b10,
        ST_STEP   = 2'b11
    } dbgm_state_e;
endpackage

// File: rtl/dbgm_event_decode.sv
// Module: classifies each debug event against the mode-enable bits.
// Produces registered one-cycle interrupt-request and trace pulses, plus a
// combinational "wait hit" that the state machine samples at the same edge.
// Assumes dbg_event is a single-cycle pulse synchronous to clk.
module dbgm_event_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic int_dbg_en,
    input  logic ext_dbg_en,
    input  logic dbg_irq_en,
    input  logic dwait_en,
    input  logic port_wait_ok,
    input  logic dbg_event,
    output logic wait_hit,
    output logic irq_pulse,
    output logic trace_pulse
);
    logic no_stop_mode;
    logic irq_hit;
    logic trace_hit;

    // Classify the current event against the enables.
    always_comb begin
        no_stop_mode = !int_dbg_en && !ext_dbg_en;
        irq_hit      = dbg_event && ext_dbg_en && dbg_irq_en;
        wait_hit     = dbg_event && no_stop_mode && dwait_en && port_wait_ok;
        trace_hit    = dbg_event && no_stop_mode && !dwait_en;
    end

    // Register the interrupt and trace pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse   <= 1'b0;
            trace_pulse <= 1'b0;
        end else begin
            irq_pulse   <= irq_hit;
            trace_pulse <= trace_hit;
        end
    end

    p_irq_needs_edm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(ext_dbg_en) && $past(dbg_irq_en)));
    p_trace_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trace_pulse |-> !($past(int_dbg_en) || $past(ext_dbg_en) || $past(dwait_en)));
    p_pulse_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pulse && trace_pulse));
endmodule

// File: rtl/dbgm_wait_fsm.sv
// Module: debug-wait state machine (running, frozen, servicing, stepping).
// Interrupts take priority over debug-port commands while frozen. A step that
// collides with an interrupt is held until the state is frozen again.
// Assumes the commands and strobes are synchronous to clk.
module dbgm_wait_fsm
    import dbgm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wait_hit,
    input  logic        ext_irq,
    input  logic        irq_return,
    input  logic        cmd_stop,
    input  logic        cmd_run,
    input  logic        cmd_step,
    input  logic        insn_done,
    output dbgm_state_e state
);
    dbgm_state_e state_nxt;
    logic        step_held;
    logic        step_held_nxt;

    // Next-state and held-step decision.
    always_comb begin
        state_nxt     = state;
        step_held_nxt = step_held;
        unique case (state)
            ST_RUN: begin
                if (wait_hit) state_nxt = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (ext_irq) begin
                    state_nxt     = ST_SERVE;
                    step_held_nxt = step_held || cmd_step;
                end else if (cmd_run) begin
                    state_nxt     = ST_RUN;
                    step_held_nxt = 1'b0;
                end else if (cmd_step || step_held) begin
                    state_nxt     = ST_STEP;
                    step_held_nxt = 1'b0;
                end
            end
            ST_SERVE: begin
                if (irq_return) state_nxt = ST_FROZEN;
            end
            ST_STEP: begin
                if (insn_done || cmd_stop) state_nxt = ST_FROZEN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // State and held-step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            step_held <= 1'b0;
        end else begin
            state     <= state_nxt;
            step_held <= step_held_nxt;
        end
    end

    p_return_refreezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVE && irq_return) |=> (state == ST_FROZEN));
    p_step_refreezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STEP && insn_done) |=> (state == ST_FROZEN));
    p_irq_beats_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FROZEN && ext_irq && cmd_step) |=> (state == ST_SERVE));
    p_run_cmd_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wait_hit) |=> (state == ST_RUN));
    p_held_only_when_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_held |-> (state == ST_SERVE || state == ST_FROZEN));
endmodule

// File: rtl/dbgm_status_out.sv
// Module: turns the controller state into freeze, grant and status outputs.
// Purely combinational. Assumes the state input comes from a register.
module dbgm_status_out
    import dbgm_pkg::*;
(
    input  dbgm_state_e         state,
    output logic                core_freeze,
    output logic                irq_grant,
    output logic [STATUS_W-1:0] status
);
    // Decode the state into the core-facing controls.
    always_comb begin
        core_freeze = (state == ST_FROZEN);
        irq_grant   = (state == ST_SERVE);
        status      = state;
    end
endmodule

// File: rtl/dbg_mode_ctrl.sv
// Module: top of the debug mode controller.
// Combines event classification, the debug-wait state machine and the output
// decode. All inputs are synchronous to clk. rst_n is synchronous, active low.
module dbg_mode_ctrl
    import dbgm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                int_dbg_en,
    input  logic                ext_dbg_en,
    input  logic                dbg_irq_en,
    input  logic                dwait_en,
    input  logic                port_wait_ok,
    input  logic                dbg_event,
    input  logic                ext_irq,
    input  logic                irq_return,
    input  logic                cmd_stop,
    input  logic                cmd_run,
    input  logic                cmd_step,
    input  logic                insn_done,
    output logic                core_freeze,
    output logic                dbg_irq_req,
    output logic                irq_grant,
    output logic                trace_trig,
    output logic [STATUS_W-1:0] status
);
    logic        wait_hit;
    dbgm_state_e state;

    dbgm_event_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .int_dbg_en   (int_dbg_en),
        .ext_dbg_en   (ext_dbg_en),
        .dbg_irq_en   (dbg_irq_en),
        .dwait_en     (dwait_en),
        .port_wait_ok (port_wait_ok),
        .dbg_event    (dbg_event),
        .wait_hit     (wait_hit),
        .irq_pulse    (dbg_irq_req),
        .trace_pulse  (trace_trig)
    );

    dbgm_wait_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_hit   (wait_hit),
        .ext_irq    (ext_irq),
        .irq_return (irq_return),
        .cmd_stop   (cmd_stop),
        .cmd_run    (cmd_run),
        .cmd_step   (cmd_step),
        .insn_done  (insn_done),
        .state      (state)
    );

    dbgm_status_out u_out (
        .state       (state),
        .core_freeze (core_freeze),
        .irq_grant   (irq_grant),
        .status      (status)
    );

    p_one_role_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_freeze, irq_grant}));
    p_freeze_from_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_freeze) |-> ($past(status) != 2'b00 || $past(dwait_en)));
    p_run_unfreezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_freeze && cmd_run && !ext_irq) |=> (status == 2'b00));
    p_stop_in_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_freeze && cmd_stop && !ext_irq && !cmd_run && !cmd_step) |=> core_freeze || (status == 2'b11));
endmodule

// File: tb/sim_dbg_mode_ctrl.sv
module sim_dbg_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idm = 0, edm = 0, die = 0, dw = 0, ok = 0, ev = 0;
    logic irq = 0, ret = 0, stp = 0, run = 0, stepc = 0, done = 0;
    logic       core_freeze, dbg_irq_req, irq_grant, trace_trig;
    logic [1:0] status;

    int vectors = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural reference: 0 running, 1 frozen, 2 servicing, 3 stepping.
    int m_st = 0;
    bit m_pend = 0;
    bit m_irq = 0;
    bit m_trace = 0;

    always #2 clk = ~clk;

    dbg_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .int_dbg_en(idm), .ext_dbg_en(edm),
        .dbg_irq_en(die), .dwait_en(dw), .port_wait_ok(ok), .dbg_event(ev),
        .ext_irq(irq), .irq_return(ret), .cmd_stop(stp), .cmd_run(run),
        .cmd_step(stepc), .insn_done(done), .core_freeze(core_freeze),
        .dbg_irq_req(dbg_irq_req), .irq_grant(irq_grant),
        .trace_trig(trace_trig), .status(status)
    );

    task automatic model_edge();
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_irq = 0; m_trace = 0;
        end else begin
            m_irq   = ev && edm && die;
            m_trace = ev && !idm && !edm && !dw;
            case (m_st)
                0: if (ev && !idm && !edm && dw && ok) m_st = 1;
                1: begin
                    if (irq) begin
                        m_st = 2;
                        if (stepc) m_pend = 1;
                    end else if (run) begin
                        m_st = 0; m_pend = 0;
                    end else if (stepc || m_pend) begin
                        m_st = 3; m_pend = 0;
                    end
                end
                2: if (ret) m_st = 1;
                default: if (done || stp) m_st = 1;
            endcase
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk({"R10 status ", tag}, int'(status), m_st);
        chk({"R2 freeze ", tag}, int'(core_freeze), int'(m_st == 1));
        chk({"R3 grant ", tag}, int'(irq_grant), int'(m_st == 2));
        chk({"R1 irq_req ", tag}, int'(dbg_irq_req), int'(m_irq));
        chk({"R4 trace ", tag}, int'(trace_trig), int'(m_trace));
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input string tag, input logic e, input logic i_, input logic s,
                       input logic r, input logic c_st, input logic c_run,
                       input logic c_step, input logic d);
        ev = e; irq = i_; stp = s; ret = r; run = c_run; stepc = c_step;
        stp = c_st; done = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic modes(input logic a, input logic b, input logic c,
                         input logic d, input logic e);
        idm = a; edm = b; die = c; dw = d; ok = e;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        for (int k = 0; k < 3; k++) cyc("R11 reset", 1, 1, 0, 0, 0, 1, 1, 1);
        rst_n = 1;
        cyc("R11 idle", 0, 0, 0, 0, 0, 0, 0, 0);

        // R4: trace with no stopping mode
        modes(0, 0, 0, 0, 0);
        cyc("R4 event", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R4 after", 0, 0, 0, 0, 0, 0, 0, 0);
        // R5: each enable suppresses trace
        modes(1, 0, 0, 0, 0); cyc("R5 idm", 1, 0, 0, 0, 0, 0, 0, 0);
        modes(0, 0, 0, 1, 0); cyc("R5 dw no-ok", 1, 0, 0, 0, 0, 0, 0, 0);
        // R1: external debug + interrupt enable
        modes(0, 1, 1, 0, 0); cyc("R1 req", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1 one-cycle", 0, 0, 0, 0, 0, 0, 0, 0);
        modes(0, 1, 0, 1, 1); cyc("R1 die low", 1, 0, 0, 0, 0, 0, 0, 0);
        modes(1, 0, 1, 1, 1); cyc("R2 idm blocks", 1, 0, 0, 0, 0, 0, 0, 0);
        // R12: commands while running do nothing
        cyc("R12 cmds", 0, 1, 1, 1, 1, 1, 1, 1);

        // R2: enter frozen
        modes(0, 0, 0, 1, 1);
        cyc("R2 enter", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R12 event frozen", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R8 stop frozen", 0, 0, 0, 0, 1, 0, 0, 0);
        // R3: interrupt service and return
        cyc("R3 irq", 0, 1, 0, 0, 0, 0, 0, 0);
        cyc("R3 serving", 0, 0, 0, 0, 0, 0, 0, 1);
        cyc("R3 return", 0, 0, 0, 1, 0, 0, 0, 0);
        // R6: step, wait, complete
        cyc("R6 step", 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R6 waiting", 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6 done", 0, 0, 0, 0, 0, 0, 0, 1);
        // R8: stop during step
        cyc("R8 step", 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R8 stop", 0, 0, 0, 0, 1, 0, 0, 0);
        // R9: collision
        cyc("R9 irq+step", 0, 1, 0, 0, 0, 0, 1, 0);
        cyc("R9 serving", 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R9 return", 0, 0, 0, 1, 0, 0, 0, 0);
        cyc("R9 held step", 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R9 done", 0, 0, 0, 0, 0, 0, 0, 1);
        // R7: run
        cyc("R7 run", 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R7 running", 0, 0, 0, 0, 0, 0, 0, 0);

        // Pseudo-random stretch against the model
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int n = 0; n < 3000; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                rst_n = (lfsr[15:10] != 6'd0);
                modes(lfsr[0] & lfsr[1] & lfsr[2], lfsr[3] & lfsr[4], lfsr[5],
                      lfsr[6] | lfsr[7], lfsr[8] | lfsr[2]);
                cyc("R12 random", lfsr[9] & lfsr[1], lfsr[11] & lfsr[3],
                    lfsr[13] & lfsr[5], lfsr[12], lfsr[14] & lfsr[0] & lfsr[6],
                    lfsr[10] & lfsr[15] & lfsr[4], lfsr[7] & lfsr[13],
                    lfsr[15] ^ lfsr[8]);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule